// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block is the data-register side of a debug access port. An external debugger uses it to read and write a 128-entry, 32-bit register space over a serial test link. Each scan moves a 40-bit frame. Bits [31:0] carry data, bits [38:32] carry a register address, and bit 39 selects the direction: 1 requests a write and 0 requests a read. The frame is shifted through the chain LSB first. The tap controller supplies one-cycle capture, shift and update enables in the system clock domain. A select input tells the chain when the tap holds the register-access instruction with this chain chosen.

An update that requests a write issues a one-cycle write strobe with the frame's address and data. An update that requests a read issues a one-cycle read strobe. The bus must return read data one cycle after that strobe, and the chain keeps the value. The value comes back through the data field of the next scan's capture, so read results are pipelined by one scan. Some registers change state when they are read, such as a trace-data pop. A debugger reading such a register in a burst keeps the address on it for each scan and points the last scan at a harmless register.

Top module: `jtag_reg_chain`

## Requirements
- R1: After reset, reg_wr and reg_rd are 0, reg_addr is 0, tdo is 0. The data field captured before any read has completed is 0.
- R2: On a selected capture, frame bits [31:0] load the kept read result and bits [39:32] load 0. The full 40-bit value then shifts out.
- R3: Each selected shift cycle moves the frame one place toward tdo, with tdi entering at bit 39. tdo always shows frame bit 0, so the frame leaves LSB first.
- R4: A selected update with frame bit 39 = 1 raises reg_wr for exactly one cycle, in the cycle after the update. In that cycle reg_addr equals frame bits [38:32] and reg_wdata equals frame bits [31:0]. reg_rd stays 0.
- R5: A selected update with frame bit 39 = 0 raises reg_rd for exactly one cycle, in the cycle after the update, with reg_addr equal to frame bits [38:32]. reg_wr stays 0.
- R6: reg_rdata is sampled one cycle after the read strobe. That value is what the data field of the next scan carries.
- R7: While sel is 0, capture, shift and update have no effect. No strobe is issued and the kept read result is unchanged.
- R8: A write scan does not alter the kept read result. The scan after a write still returns the data of the last read.
- R9: Each read scan strobes the bus exactly once. A burst of reads on a side-effect address therefore pops once per scan. A closing read of another address adds no extra pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, tap enables are synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chain selected (register-access instruction and this chain active) |
| capture_dr | input | 1 | Capture enable from the tap controller |
| shift_dr | input | 1 | Shift enable from the tap controller |
| update_dr | input | 1 | Update enable from the tap controller, one cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, frame bit 0 |
| reg_addr | output | 7 | Register address of the last update |
| reg_wdata | output | 32 | Write data of the last write update |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Read data, valid one cycle after reg_rd |

## Verification
The assertions assume a few things about the inputs:
- At most one of capture, shift and update is active in a cycle.
- Update lasts a single cycle.
- The bus answers exactly one cycle after a read strobe.
- No capture follows a read update within two cycles, since that capture would take the previous result.

The stimulus drives the enables one at a time from a scan task on the falling edge. It leaves three idle cycles after every update. Its bus model registers the read data on the edge that sees the read strobe.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_op_e;

    function automatic bus_op_e op_from_flag(input logic write_flag);
        return write_flag ? BUS_WRITE : BUS_READ;
    endfunction

endpackage

// File: rtl/jscan_shift.sv
module jscan_shift #(
    parameter int DATA_W  = 32,
    parameter int FRAME_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap,
    input  logic               sh,
    input  logic               tdi,
    input  logic [DATA_W-1:0]  cap_data,
    output logic [FRAME_W-1:0] frame,
    output logic               tdo
);
    localparam int TOP_W = FRAME_W - DATA_W;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.frame = {{TOP_W{1'b0}}, cap_data};
        end else if (sh) begin
            st_d.frame = {tdi, st_q.frame[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame = st_q.frame;
    assign tdo   = st_q.frame[0];

    // R2: capture clears address and direction bits
    a_r2_capture_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (frame[FRAME_W-1:DATA_W] == '0));

    // R3: the next bit reaches tdo after one shift
    a_r3_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sh && !cap) |=> (tdo == $past(frame[1])));

    // R7: no enable, frame held
    a_r7_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh && !cap) |=> $stable(frame));

endmodule

// File: rtl/jscan_bus.sv
module jscan_bus
    import jscan_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 7,
    parameter int FRAME_W = DATA_W + ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd,
    input  logic [FRAME_W-1:0] frame,
    input  logic [DATA_W-1:0]  rdata,
    output logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  wdata,
    output logic               wr_en,
    output logic               rd_en,
    output logic [DATA_W-1:0]  hold
);
    localparam int DIR_BIT = FRAME_W - 1;

    typedef struct packed {
        bus_op_e            op;
        logic               rd_late;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  hold;
    } bus_st_t;

    bus_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.op      = BUS_IDLE;
        st_d.rd_late = (st_q.op == BUS_READ);
        if (st_q.rd_late) begin
            st_d.hold = rdata;
        end
        if (upd) begin
            st_d.op   = op_from_flag(frame[DIR_BIT]);
            st_d.addr = frame[DATA_W +: ADDR_W];
            if (frame[DIR_BIT]) begin
                st_d.wdata = frame[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.op      <= BUS_IDLE;
            st_q.rd_late <= 1'b0;
            st_q.addr    <= '0;
            st_q.wdata   <= '0;
            st_q.hold    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr  = st_q.addr;
    assign wdata = st_q.wdata;
    assign wr_en = (st_q.op == BUS_WRITE);
    assign rd_en = (st_q.op == BUS_READ);
    assign hold  = st_q.hold;

    // R4: write strobe lasts one cycle
    a_r4_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !upd) |=> !wr_en);

    // R5: read strobe lasts one cycle
    a_r5_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !upd) |=> !rd_en);

    // R4 and R5: an update always yields a strobe
    a_r5_update_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (wr_en || rd_en));

    // R7: without update the bus stays quiet
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> (!wr_en && !rd_en));

    // R8: the kept result moves only at the read sampling cycle
    a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rd_late |=> $stable(hold));

    // R6: the bus value is taken one cycle after the strobe
    a_r6_sample_late: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 (hold == $past(rdata)));

endmodule

// File: rtl/jtag_reg_chain.sv
module jtag_reg_chain #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    logic               cap_en, sh_en, upd_en;
    logic [FRAME_W-1:0] frame;
    logic [DATA_W-1:0]  hold;

    assign cap_en = sel && capture_dr;
    assign sh_en  = sel && shift_dr;
    assign upd_en = sel && update_dr;

    jscan_shift #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap_en),
        .sh       (sh_en),
        .tdi      (tdi),
        .cap_data (hold),
        .frame    (frame),
        .tdo      (tdo)
    );

    jscan_bus #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .FRAME_W (FRAME_W)
    ) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd_en),
        .frame (frame),
        .rdata (reg_rdata),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .wr_en (reg_wr),
        .rd_en (reg_rd),
        .hold  (hold)
    );

    // R7: a deselected chain issues no strobe
    a_r7_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (!reg_wr && !reg_rd));

endmodule

// File: tb/jtag_reg_chain_test.sv
module jtag_reg_chain_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        capture_dr = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [31:0] reg_rdata = 32'h0;

    localparam logic [31:0] POP_BASE = 32'hF1F0_0000;
    localparam logic [31:0] ID_VAL   = 32'h1D5E_C0DE;

    always #10 clk = ~clk;

    jtag_reg_chain uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // bus model: address 4 pops on every read, others are plain storage
    logic [31:0] mem [128];
    int          pops = 0;
    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'h0;
        mem[0] = ID_VAL;
    end
    always @(posedge clk) begin
        if (reg_wr) mem[reg_addr] <= reg_wdata;
        if (reg_rd) begin
            if (reg_addr == 7'd4) begin
                reg_rdata <= POP_BASE + pops;
                pops++;
            end else begin
                reg_rdata <= mem[reg_addr];
            end
        end
    end

    // scoreboard
    typedef struct {
        logic        wr;
        logic [6:0]  a;
        logic [31:0] d;
    } ev_t;
    ev_t         evq[$];
    logic [31:0] shadow [128];
    int          exp_pops = 0;
    logic [31:0] exp_hold = 32'h0;

    initial begin
        for (int i = 0; i < 128; i++) shadow[i] = 32'h0;
        shadow[0] = ID_VAL;
    end

    always @(negedge clk) begin
        if (rst_n && (reg_wr || reg_rd)) begin
            if (evq.size() == 0) begin
                check("R7 unexpected strobe", {38'h0, reg_wr, reg_rd}, 40'h0);
            end else begin
                ev_t e;
                e = evq.pop_front();
                check(e.wr ? "R4 strobe kind" : "R5 strobe kind",
                      {38'h0, reg_wr, reg_rd}, {38'h0, e.wr, !e.wr});
                check(e.wr ? "R4 address" : "R5 address",
                      {33'h0, reg_addr}, {33'h0, e.a});
                if (e.wr) check("R4 write data", {8'h0, reg_wdata}, {8'h0, e.d});
            end
        end
    end

    task automatic scan(input logic s, input logic [39:0] din, output logic [39:0] dout);
        sel = s;
        @(negedge clk);
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0;
        shift_dr   = 1'b1;
        for (int i = 0; i < 40; i++) begin
            dout[i] = tdo;
            tdi     = din[i];
            @(negedge clk);
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
        repeat (3) @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic do_write(input string tag, input logic [6:0] a, input logic [31:0] d);
        logic [39:0] out;
        ev_t e;
        e.wr = 1'b1; e.a = a; e.d = d;
        evq.push_back(e);
        shadow[a] = d;
        scan(1'b1, {1'b1, a, d}, out);
        check(tag, out, {8'h0, exp_hold});
    endtask

    task automatic do_read(input string tag, input logic [6:0] a);
        logic [39:0] out;
        ev_t e;
        e.wr = 1'b0; e.a = a; e.d = 32'h0;
        evq.push_back(e);
        scan(1'b1, {1'b0, a, 32'hCAFE_0000}, out);
        check(tag, out, {8'h0, exp_hold});
        if (a == 7'd4) begin
            exp_hold = POP_BASE + exp_pops;
            exp_pops++;
        end else begin
            exp_hold = shadow[a];
        end
    endtask

    initial begin
        logic [39:0] out;
        repeat (3) @(negedge clk);
        check("R1 reset wr", {39'h0, reg_wr}, 40'h0);
        check("R1 reset rd", {39'h0, reg_rd}, 40'h0);
        check("R1 reset addr", {33'h0, reg_addr}, 40'h0);
        check("R1 reset tdo", {39'h0, tdo}, 40'h0);
        rst_n = 1'b1;
        @(negedge clk);

        do_write("R1 first capture zero", 7'd10, 32'hA5A5_0F0F);
        do_write("R2 capture before read", 7'h7F, 32'hDEAD_BEEF);
        do_write("R3 bit order", 7'h41, 32'h8000_0001);
        do_read ("R2 read request", 7'd10);
        do_write("R6 read result in next scan", 7'd20, 32'h0000_1234);
        do_read ("R8 write keeps result", 7'h7F);

        // deselected scan: no strobe, no capture, no update
        scan(1'b0, {1'b1, 7'd10, 32'h0}, out);
        do_read ("R7 deselected scan ignored", 7'd10);
        do_read ("R7 write while deselected ignored", 7'h41);

        // burst on the pop address, closed by an identity read
        do_read ("R9 burst first", 7'd4);
        do_read ("R9 burst second", 7'd4);
        do_read ("R9 burst third", 7'd4);
        do_read ("R9 burst closing", 7'd0);
        do_read ("R9 identity result", 7'd20);
        do_write("R6 last read result", 7'd30, 32'h0);

        repeat (3) @(negedge clk);
        check("R9 pop count", 40'(pops), 40'(exp_pops));
        check("R4 all strobes seen", 40'(evq.size()), 40'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule